// File: doc/BRIEF.md
# Flash Converter Thermometer-to-Binary Encoder

This block is the digital back end of an 8-bit flash converter. On each rising edge of the convert clock it captures a 255-bit comparator vector. Each bit is set when the reference level it stands for lies below the analog input, so a clean sample is a run of ones starting at the lowest reference. On the following edge it registers a binary word equal to the number of set bits.

The encoder counts ones rather than searching for the top of the run. An isolated bubble, a zero with ones above it, therefore moves the result by no more than one code. Two active-low format controls sit between the encoder and the output register. One flips the top output bit and the other flips the seven lower bits. Together they select true binary, inverted binary, offset twos complement or inverted offset twos complement. The controls are sampled on the same edge that loads the output. Both are meant to be tied high when unused, which gives true binary.

Top module: `therm_flash_encoder`

## Requirements
- R1: While rst_n is low, the captured sample and dout are both cleared to 8'h00. This is the unformatted zero, whatever the format controls are set to.
- R2: With both format controls high, dout equals the count of set bits in the sampled vector, from 0 to 255.
- R3: An all-zeros vector gives code 0 and an all-ones vector gives code 255. There is no wrap.
- R4: A vector captured at convert edge N appears on dout just after edge N+1. dout does not change between edges.
- R5: When msb_flip_n is low, bit 7 of dout is the inverse of the count's bit 7.
- R6: When low_flip_n is low, bits 6 to 0 of dout are the inverse of the count's bits 6 to 0.
- R7: The four formats give these values. Both controls high maps 0 to 00000000. Both low maps 0 to 11111111. msb_flip_n low alone maps 0 to 10000000 and 255 to 01111111. low_flip_n low alone maps 0 to 01111111 and 255 to 10000000.
- R8: The format controls are sampled on the edge that loads dout. A change takes effect on the next edge, with no extra delay, and applies to the word already in flight.
- R9: A thermometer with a single bubble (one zero below the top set bit) decodes to within one LSB of its ideal code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Convert strobe; rising edge samples the vector and advances the pipeline |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmp_vec | input | 255 | Comparator outputs; bit 0 is the lowest reference |
| msb_flip_n | input | 1 | Active-low inversion of output bit 7 (tie high if unused) |
| low_flip_n | input | 1 | Active-low inversion of output bits 6..0 (tie high if unused) |
| dout | output | 8 | Registered, formatted conversion result |

## Verification
A wrong count or a dropped comparator bit shows on dout two edges after the faulty vector enters. It is caught at once, because the reference model predicts every output word. A fault in the inversion mask, or sampling the controls on the wrong edge, shows one edge after a control change. The directed cases toggle each control in isolation at code 0 and code 255 to expose exactly that. A pipeline depth that is too short or too long misaligns every later word, so the first random step after the directed cases already reports it.

// File: rtl/therm_flash_encoder.sv
module therm_flash_encoder #(
  parameter int LEVELS = 255,
  localparam int CW = $clog2(LEVELS + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [LEVELS-1:0] cmp_vec,
  input  logic              msb_flip_n,
  input  logic              low_flip_n,
  output logic [CW-1:0]     dout
);

  function automatic logic [CW-1:0] ones_count(input logic [LEVELS-1:0] v);
    logic [CW-1:0] n;
    n = '0;
    for (int i = 0; i < LEVELS; i++) n = n + CW'(v[i]);
    return n;
  endfunction

  logic [LEVELS-1:0] samp_q;
  logic [CW-1:0]     code;
  logic [CW-1:0]     fmt_mask;

  assign code     = ones_count(samp_q);
  assign fmt_mask = {~msb_flip_n, {(CW-1){~low_flip_n}}};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      samp_q <= '0;
      dout   <= '0;
    end else begin
      samp_q <= cmp_vec;
      dout   <= code ^ fmt_mask;
    end
  end

  logic [1:0]    run_cnt;
  logic [CW-1:0] in_count;
  assign in_count = ones_count(cmp_vec);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) run_cnt <= '0;
    else if (run_cnt != 2'd3) run_cnt <= run_cnt + 2'd1;
  end

  AST_PIPE_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    (run_cnt >= 2'd2) |->
      ((dout ^ {~$past(msb_flip_n), {(CW-1){~$past(low_flip_n)}}}) == $past(in_count, 2))); // R4

  AST_FULL_SCALE: assert property (@(posedge clk) disable iff (!rst_n)
    (run_cnt >= 2'd2 && $past(&cmp_vec, 2) && $past(msb_flip_n) && $past(low_flip_n))
      |-> (dout == {CW{1'b1}})); // R3

  AST_ZERO_SCALE: assert property (@(posedge clk) disable iff (!rst_n)
    (run_cnt >= 2'd2 && $past(~|cmp_vec, 2) && $past(msb_flip_n) && $past(low_flip_n))
      |-> (dout == '0)); // R3

  AST_MSB_FLIP: assert property (@(posedge clk) disable iff (!rst_n)
    (run_cnt >= 2'd1 && !$past(msb_flip_n)) |-> (dout[CW-1] == ~$past(code[CW-1]))); // R5

  AST_LOW_FLIP: assert property (@(posedge clk) disable iff (!rst_n)
    (run_cnt >= 2'd1 && !$past(low_flip_n)) |-> (dout[CW-2:0] == ~$past(code[CW-2:0]))); // R6

endmodule

// File: tb/sim_therm_flash_encoder.sv
module sim_therm_flash_encoder;
  localparam int L = 255;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [L-1:0] cmp_vec = '0;
  logic         msb_flip_n = 1'b1;
  logic         low_flip_n = 1'b1;
  logic [7:0]   dout;

  int total = 0;
  int bad = 0;
  logic [7:0] mdl_s1 = '0;
  logic [7:0] mdl_out = '0;

  therm_flash_encoder u0 (.clk(clk), .rst_n(rst_n), .cmp_vec(cmp_vec),
    .msb_flip_n(msb_flip_n), .low_flip_n(low_flip_n), .dout(dout));

  always #4 clk = ~clk;

  function automatic logic [7:0] cnt(input logic [L-1:0] v);
    int n = 0;
    for (int i = 0; i < L; i++) if (v[i]) n++;
    return 8'(n);
  endfunction

  function automatic logic [L-1:0] thermo(input int k);
    logic [L-1:0] v = '0;
    for (int i = 0; i < k; i++) v[i] = 1'b1;
    return v;
  endfunction

  function automatic logic [7:0] fmt(input logic [7:0] c, input logic m, input logic l);
    return {c[7] ^ ~m, c[6:0] ^ {7{~l}}};
  endfunction

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: dout=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step(input logic [L-1:0] v, input logic m, input logic l, input string req);
    cmp_vec = v; msb_flip_n = m; low_flip_n = l;
    @(posedge clk);
    mdl_out = fmt(mdl_s1, m, l);
    mdl_s1 = cnt(v);
    @(negedge clk);
    check(req, dout, mdl_out);
  endtask

  initial begin
    #1_000_000;
    bad++;
    $display("FAIL watchdog: dout=%h expected=end of run", dout);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [L-1:0] v;
    int k, b;
    void'($urandom(32'd7331));
    msb_flip_n = 1'b0; low_flip_n = 1'b0;
    repeat (3) @(negedge clk);
    check("R1 reset clears raw zero", dout, 8'h00);
    rst_n = 1'b1;
    @(negedge clk);
    step('0, 1, 1, "R1");

    step('0, 1, 1, "R3 zero");
    step({L{1'b1}}, 1, 1, "R3 zero out");
    step({L{1'b1}}, 1, 1, "R3 full scale");
    step(thermo(127), 1, 1, "R2 full");
    step(thermo(128), 1, 1, "R2 127");
    step('0, 1, 1, "R2 128");
    // R4: inputs change between edges, output must hold
    cmp_vec = {L{1'b1}}; msb_flip_n = 0; low_flip_n = 0;
    #2 check("R4 hold between edges", dout, mdl_out);
    step('0, 1, 1, "R4 after hold");
    // R7 / R5 / R6: four formats at code 0 and 255
    step({L{1'b1}}, 0, 0, "R7 both low 0->FF");
    step('0, 0, 1, "R7 R5 offset 255->7F");
    step({L{1'b1}}, 0, 1, "R7 R5 offset 0->80");
    step('0, 1, 0, "R7 R6 inverted 255->80");
    step('0, 1, 0, "R7 R6 inverted 0->7F");
    // R8: control change applies to the word already in flight
    step(thermo(5), 1, 1, "R8 setup");
    step(thermo(9), 0, 1, "R8 control takes effect next edge");
    step(thermo(9), 1, 1, "R8 back to true");
    // R9: single bubble
    for (int j = 0; j < 20; j++) begin
      k = 2 + ($urandom % (L - 1));
      b = $urandom % (k - 1);
      v = thermo(k); v[b] = 1'b0;
      step(v, 1, 1, "R9 setup");
      step('0, 1, 1, "R9 bubble");
      total++;
      if (int'(dout) < k - 1 || int'(dout) > k) begin
        bad++;
        $display("FAIL R9: dout=%0d expected=%0d within one", dout, k);
      end
    end
    // Random mix
    for (int j = 0; j < 400; j++) begin
      case ($urandom % 3)
        0: v = thermo($urandom % (L + 1));
        1: begin k = 2 + ($urandom % (L - 1)); v = thermo(k); v[$urandom % (k - 1)] = 1'b0; end
        default: for (int i = 0; i < L; i++) v[i] = 1'($urandom);
      endcase
      step(v, 1'($urandom), 1'($urandom), "R2 R5 R6 random");
    end
    // R1: async reset mid-run
    step({L{1'b1}}, 1, 1, "R1 pre");
    #1 rst_n = 1'b0;
    #1 check("R1 async clear", dout, 8'h00);
    mdl_s1 = '0; mdl_out = '0;
    @(negedge clk); rst_n = 1'b1;
    step({L{1'b1}}, 0, 0, "R1 stage cleared");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule